// File: doc/BRIEF.md
# Triggered Sample Record Packer

This block takes a snapshot of a set of input groups each time a sample event occurs and sends the result downstream as one record of 32-bit words on a valid/ready stream. Twenty groups exist, each with a fixed word count. A group contributes words only while its enable bit is set, so both the record length and the record layout follow the enable mask. Every record ends with a timestamp word taken from a free-running cycle counter at the moment the event is accepted.

Sample events come from one of two sources. The first is a periodic divider that fires once every N cycles. The second is a set of trigger slots, each watching one digital input for a rising edge, a falling edge or both. Most group words are fetched from an external source port that the block addresses by group and word index. The digital-input group word is built inside the block from the pin levels latched when the event is accepted.

Software writes the configuration while capture is stopped, then pulses start. A pause bit stops new events from being taken without clearing any setting. An event that arrives while a record is still being sent is dropped and sets a sticky overflow flag.

The sequencer has four states:
- STOPPED: capture is off. This is the state after reset and after a stop pulse.
- ARMED: capture is on and the block is waiting for an event.
- GROUP_WORD: the block is emitting group words.
- STAMP_WORD: the block is emitting the timestamp.

The state transitions are:
- start: any state to ARMED.
- stop: any state to STOPPED.
- launch: ARMED, or STAMP_WORD while the timestamp word is taken, to GROUP_WORD. If no group is enabled, launch goes to STAMP_WORD instead.
- group advance: GROUP_WORD to GROUP_WORD, moving to the next word or the next enabled group.
- group done: GROUP_WORD to STAMP_WORD.
- record done: STAMP_WORD to ARMED.

Top module: `sample_record_packer`

## Requirements
- R1: Enabled groups appear in ascending index order, and disabled groups take no words. The words per group for indices 0 to 19 are: 0,1,4,5,10 carry 2; 2,3,6,7 carry 4; 8,9 carry 3; 11 carries 1; 12 to 19 carry 4. For each group word, `src_grp`/`src_idx` give the group and the word within it, and `src_data` is passed through unchanged.
- R2: After the last group word, one timestamp word follows, and it is the only word with `m_last` high. A record therefore has the sum of the enabled sizes plus one words. With no group enabled, a record is the timestamp alone.
- R3: In periodic mode, accepted records carry timestamps N cycles apart, where N is the rate register. A rate of 0 behaves as 1.
- R4: While the pause bit is 1, no record starts. Clearing the pause bit resumes capture with the same layout.
- R5: In external mode, the periodic divider is ignored. A slot fires on a rising edge when its bit 0 is set and on a falling edge when its bit 1 is set. Timestamps of the resulting records differ by the number of cycles between the edges.
- R6: Slot s is held in register 4+s/4, byte lane s%4. In that byte, bit 0 selects rising edges, bit 1 selects falling edges and bits 6:2 hold a flat input number. A flat number of 10 or more selects module 1, channel number minus 10, which is pin 10+channel; a smaller number selects module 0, which is pin number.
- R7: The digital-input group (index 10) carries both of its words as the latched pins. Pin c sits at bit c when c<10 and at bit c+6 otherwise. All other bits are 0.
- R8: Writes to the enable register (address 0), the source-select register (address 3, bit 0 = external) and the slot registers are ignored while capture runs. The rate (address 1) and pause (address 2, bit 0) registers can be written at any time.
- R9: An event that arrives while a record is still in flight is dropped and sets `overflow`. The flag stays set until a start pulse clears it.
- R10: A start pulse discards any partial record and rearms capture. A stop pulse discards any partial record and halts capture. Stop wins if both pulses arrive together.
- R11: While `m_valid` is high and `m_ready` is low, `m_data` and `m_last` hold their values.
- R12: After reset, capture is stopped, `m_valid` is 0 and `overflow` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_start | input | 1 | Pulse: clear overflow, flush, begin capture |
| run_stop | input | 1 | Pulse: flush and halt capture |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| din | input | 26 | Digital inputs (trigger sources and group 10 content) |
| src_grp | output | 5 | Group index of the word being fetched |
| src_idx | output | 2 | Word index within that group |
| src_data | input | 32 | Group word returned by the sources, same cycle |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Downstream accepts the word |
| m_data | output | 32 | Output word |
| m_last | output | 1 | Marks the timestamp word that ends a record |
| overflow | output | 1 | Sticky flag: an event was dropped |

## Verification
On every cycle, the assertions check that the stream holds its word under backpressure, that both flush pulses empty the output on the next cycle, that the overflow flag is sticky and is cleared by start, that pause blocks the event pulse, and the reset state. Only the bench scenarios can show the following: the record layout for each enable mask and its group word sizes, the bit placement of the digital-input word, timestamp spacing for both periodic and edge events, slot register decoding, and that locked writes leave the layout and source unchanged while capture runs.

// File: rtl/srp_pkg.sv
package srp_pkg;
    localparam int NGRP   = 20;
    localparam int DI_GRP = 10;

    typedef enum logic [1:0] {ST_STOP, ST_IDLE, ST_GROUP, ST_STAMP} srp_state_e;

    typedef struct packed {
        logic       rise;
        logic       fall;
        logic       mod;
        logic [4:0] chan;
    } slot_cfg_t;

    // words carried by each group
    function automatic logic [2:0] grp_words(input logic [4:0] g);
        case (g)
            5'd0, 5'd1, 5'd4, 5'd5, 5'd10: return 3'd2;
            5'd2, 5'd3, 5'd6, 5'd7:        return 3'd4;
            5'd8, 5'd9:                    return 3'd3;
            5'd11:                         return 3'd1;
            default:                       return 3'd4;
        endcase
    endfunction

    // lowest enabled group at or above 'from'; NGRP when none is left
    function automatic logic [4:0] next_en(input logic [NGRP-1:0] en, input logic [5:0] from);
        logic [4:0] r;
        logic       found;
        r     = 5'(NGRP);
        found = 1'b0;
        for (int i = 0; i < NGRP; i++) begin
            if (!found && en[i] && (6'(i) >= from)) begin
                r     = 5'(i);
                found = 1'b1;
            end
        end
        return r;
    endfunction

    // one byte lane of a slot register -> decoded slot
    function automatic slot_cfg_t decode_slot(input logic [7:0] lane);
        slot_cfg_t  s;
        logic [4:0] num;
        num    = lane[6:2];
        s.rise = lane[0];
        s.fall = lane[1];
        s.mod  = (num >= 5'd10);
        s.chan = (num >= 5'd10) ? (num - 5'd10) : num;
        return s;
    endfunction
endpackage

// File: rtl/srp_cfg_regs.sv
module srp_cfg_regs
    import srp_pkg::*;
#(
    parameter int RATE_W    = 16,
    parameter int NUM_SLOTS = 8,
    parameter int ADDR_W    = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   running,
    input  logic                   cfg_we,
    input  logic [ADDR_W-1:0]      cfg_addr,
    input  logic [31:0]            cfg_wdata,
    output logic [NGRP-1:0]        grp_en,
    output logic [RATE_W-1:0]      rate,
    output logic                   pause,
    output logic                   ext_sel,
    output slot_cfg_t [NUM_SLOTS-1:0] slots
);
    localparam int A_ENABLE = 0;
    localparam int A_RATE   = 1;
    localparam int A_PAUSE  = 2;
    localparam int A_SOURCE = 3;
    localparam int A_SLOT0  = 4;

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_en  <= '0;
            rate    <= '0;
            pause   <= 1'b0;
            ext_sel <= 1'b0;
            slots   <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == ADDR_W'(A_ENABLE) && !running)
                grp_en <= cfg_wdata[NGRP-1:0];
            if (cfg_addr == ADDR_W'(A_RATE))
                rate <= cfg_wdata[RATE_W-1:0];
            if (cfg_addr == ADDR_W'(A_PAUSE))
                pause <= cfg_wdata[0];
            if (cfg_addr == ADDR_W'(A_SOURCE) && !running)
                ext_sel <= cfg_wdata[0];
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (!running && cfg_addr == ADDR_W'(A_SLOT0 + s / 4))
                    slots[s] <= decode_slot(cfg_wdata[8*(s%4) +: 8]);
            end
        end
    end
endmodule

// File: rtl/srp_trigger.sv
module srp_trigger
    import srp_pkg::*;
#(
    parameter int RATE_W    = 16,
    parameter int NUM_SLOTS = 8,
    parameter int NUM_PINS  = 26
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      running,
    input  logic                      hold,
    input  logic                      pause,
    input  logic                      ext_sel,
    input  logic [RATE_W-1:0]         rate,
    input  slot_cfg_t [NUM_SLOTS-1:0] slots,
    input  logic [NUM_PINS-1:0]       din,
    output logic                      fire
);
    localparam int PIN_W = $clog2(NUM_PINS);

    logic [NUM_PINS-1:0]  din_q;
    logic [NUM_SLOTS-1:0] hit;
    logic [RATE_W-1:0]    div_cnt;
    logic [RATE_W-1:0]    period_m1;
    logic                 per_fire;

    always_ff @(posedge clk) begin
        if (rst) din_q <= '0;
        else     din_q <= din;
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic [5:0] pin;
        logic       h;
        assign pin = slots[s].mod ? (6'(slots[s].chan) + 6'd10) : 6'(slots[s].chan);
        always_comb begin
            h = 1'b0;
            if (pin < 6'(NUM_PINS))
                h = (slots[s].rise &  din[pin[PIN_W-1:0]] & ~din_q[pin[PIN_W-1:0]])
                  | (slots[s].fall & ~din[pin[PIN_W-1:0]] &  din_q[pin[PIN_W-1:0]]);
        end
        assign hit[s] = h;
    end

    assign period_m1 = (rate == '0) ? '0 : (rate - 1'b1);
    assign per_fire  = (div_cnt >= period_m1);

    always_ff @(posedge clk) begin
        if (rst || !running || hold || pause || ext_sel) div_cnt <= '0;
        else if (per_fire)                               div_cnt <= '0;
        else                                             div_cnt <= div_cnt + 1'b1;
    end

    assign fire = running && !hold && !pause && (ext_sel ? (|hit) : per_fire);
endmodule

// File: rtl/srp_sequencer.sv
module srp_sequencer
    import srp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            run_start,
    input  logic            run_stop,
    input  logic            fire,
    input  logic [NGRP-1:0] grp_en,
    input  logic [31:0]     di_word,
    input  logic [31:0]     stamp,
    input  logic [31:0]     src_data,
    input  logic            m_ready,
    output logic [4:0]      src_grp,
    output logic [1:0]      src_idx,
    output logic            m_valid,
    output logic [31:0]     m_data,
    output logic            m_last,
    output logic            overflow,
    output logic            running
);
    srp_state_e  state_q;
    logic [4:0]  grp_q;
    logic [1:0]  widx_q;
    logic [31:0] stamp_q;
    logic [31:0] di_q;
    logic        ovf_q;

    logic [4:0]  first_grp;
    logic [4:0]  nxt_grp;
    logic        grp_end;
    logic        launch;

    assign first_grp = next_en(grp_en, 6'd0);
    assign nxt_grp   = next_en(grp_en, 6'(grp_q) + 6'd1);
    assign grp_end   = (3'(widx_q) == grp_words(grp_q) - 3'd1);
    assign launch    = fire && ((state_q == ST_IDLE) || (state_q == ST_STAMP && m_ready));

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_STOP;
            grp_q   <= '0;
            widx_q  <= '0;
            stamp_q <= '0;
            di_q    <= '0;
            ovf_q   <= 1'b0;
        end else if (run_stop) begin
            state_q <= ST_STOP;
        end else if (run_start) begin
            state_q <= ST_IDLE;
            ovf_q   <= 1'b0;
        end else begin
            if (fire && !launch) ovf_q <= 1'b1;
            if (launch) begin
                stamp_q <= stamp;
                di_q    <= di_word;
                grp_q   <= first_grp;
                widx_q  <= '0;
                state_q <= (first_grp == 5'(NGRP)) ? ST_STAMP : ST_GROUP;
            end else begin
                unique case (state_q)
                    ST_STOP, ST_IDLE: ;
                    ST_GROUP: begin
                        if (m_ready) begin
                            if (grp_end) begin
                                widx_q <= '0;
                                if (nxt_grp == 5'(NGRP)) state_q <= ST_STAMP;
                                else                     grp_q   <= nxt_grp;
                            end else begin
                                widx_q <= widx_q + 2'd1;
                            end
                        end
                    end
                    ST_STAMP: if (m_ready) state_q <= ST_IDLE;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        m_valid = 1'b0;
        m_last  = 1'b0;
        m_data  = '0;
        unique case (state_q)
            ST_STOP, ST_IDLE: ;
            ST_GROUP: begin
                m_valid = 1'b1;
                m_data  = (grp_q == 5'(DI_GRP)) ? di_q : src_data;
            end
            ST_STAMP: begin
                m_valid = 1'b1;
                m_last  = 1'b1;
                m_data  = stamp_q;
            end
        endcase
    end

    assign src_grp  = grp_q;
    assign src_idx  = widx_q;
    assign overflow = ovf_q;
    assign running  = (state_q != ST_STOP);
endmodule

// File: rtl/sample_record_packer.sv
module sample_record_packer
    import srp_pkg::*;
#(
    parameter int RATE_W    = 16,
    parameter int NUM_SLOTS = 8,
    parameter int NUM_PINS  = 26,
    parameter int ADDR_W    = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run_start,
    input  logic                run_stop,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [31:0]         cfg_wdata,
    input  logic [NUM_PINS-1:0] din,
    output logic [4:0]          src_grp,
    output logic [1:0]          src_idx,
    input  logic [31:0]         src_data,
    output logic                m_valid,
    input  logic                m_ready,
    output logic [31:0]         m_data,
    output logic                m_last,
    output logic                overflow
);
    localparam int LOW_PINS = 10;
    localparam int HI_SHIFT = 6;

    logic                      running;
    logic                      cfg_pause;
    logic                      ext_sel;
    logic                      sample_fire;
    logic [NGRP-1:0]           grp_en;
    logic [RATE_W-1:0]         rate;
    slot_cfg_t [NUM_SLOTS-1:0] slots;
    logic [31:0]               stamp;
    logic [31:0]               di_word;

    always_ff @(posedge clk) begin
        if (rst) stamp <= '0;
        else     stamp <= stamp + 32'd1;
    end

    for (genvar b = 0; b < 32; b++) begin : g_di
        localparam int SRC = (b < LOW_PINS) ? b : b - HI_SHIFT;
        if ((b < LOW_PINS) ? (b < NUM_PINS) : (b >= LOW_PINS + HI_SHIFT && SRC < NUM_PINS)) begin : g_pin
            assign di_word[b] = din[SRC];
        end else begin : g_zero
            assign di_word[b] = 1'b0;
        end
    end

    srp_cfg_regs #(.RATE_W(RATE_W), .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_cfg (
        .clk(clk), .rst(rst), .running(running),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .grp_en(grp_en), .rate(rate), .pause(cfg_pause), .ext_sel(ext_sel), .slots(slots)
    );

    srp_trigger #(.RATE_W(RATE_W), .NUM_SLOTS(NUM_SLOTS), .NUM_PINS(NUM_PINS)) u_trig (
        .clk(clk), .rst(rst), .running(running), .hold(run_start | run_stop),
        .pause(cfg_pause), .ext_sel(ext_sel), .rate(rate), .slots(slots),
        .din(din), .fire(sample_fire)
    );

    srp_sequencer u_seq (
        .clk(clk), .rst(rst), .run_start(run_start), .run_stop(run_stop),
        .fire(sample_fire), .grp_en(grp_en), .di_word(di_word), .stamp(stamp),
        .src_data(src_data), .m_ready(m_ready), .src_grp(src_grp), .src_idx(src_idx),
        .m_valid(m_valid), .m_data(m_data), .m_last(m_last),
        .overflow(overflow), .running(running)
    );
endmodule

// File: rtl/srp_checker.sv
module srp_checker (
    input logic        clk,
    input logic        rst,
    input logic        run_start,
    input logic        run_stop,
    input logic        m_valid,
    input logic        m_ready,
    input logic [31:0] m_data,
    input logic        m_last,
    input logic        overflow,
    input logic        cfg_pause,
    input logic        sample_fire
);
    a_r12_reset_quiet: assert property (@(posedge clk)
        rst |=> (!m_valid && !overflow));

    a_r11_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready && !run_start && !run_stop) |=>
            (m_valid && $stable(m_data) && $stable(m_last)));

    a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        (overflow && !run_start) |=> overflow);

    a_r9_start_clears: assert property (@(posedge clk) disable iff (rst)
        (run_start && !run_stop) |=> !overflow);

    a_r10_stop_flush: assert property (@(posedge clk) disable iff (rst)
        run_stop |=> !m_valid);

    a_r10_start_flush: assert property (@(posedge clk) disable iff (rst)
        run_start |=> !m_valid);

    a_r4_pause_blocks: assert property (@(posedge clk) disable iff (rst)
        cfg_pause |-> !sample_fire);
endmodule

bind sample_record_packer srp_checker u_chk (
    .clk(clk), .rst(rst), .run_start(run_start), .run_stop(run_stop),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
    .overflow(overflow), .cfg_pause(cfg_pause), .sample_fire(sample_fire)
);

// File: tb/sample_record_packer_test.sv
module sample_record_packer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_start = 1'b0;
    logic        run_stop = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [25:0] din = '0;
    logic [4:0]  src_grp;
    logic [1:0]  src_idx;
    logic [31:0] src_data;
    logic        m_valid;
    logic        m_ready = 1'b1;
    logic [31:0] m_data;
    logic        m_last;
    logic        overflow;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;
    logic [31:0] exp_w [0:71];
    int exp_len = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign src_data = {8'hA5, 3'b000, src_grp, 6'b000000, src_idx, 8'h3C};

    sample_record_packer uut (
        .clk(clk), .rst(rst), .run_start(run_start), .run_stop(run_stop),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .din(din),
        .src_grp(src_grp), .src_idx(src_idx), .src_data(src_data),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
        .overflow(overflow)
    );

    function automatic int gsize(int g);
        if (g == 11) return 1;
        if (g == 8 || g == 9) return 3;
        if (g == 0 || g == 1 || g == 4 || g == 5 || g == 10) return 2;
        return 4;
    endfunction

    function automatic logic [31:0] src_model(int g, int w);
        return {8'hA5, 3'b000, 5'(g), 6'b000000, 2'(w), 8'h3C};
    endfunction

    function automatic logic [31:0] di_model(logic [25:0] d);
        logic [31:0] r = '0;
        for (int c = 0; c < 26; c++) begin
            if (c < 10) r[c] = d[c];
            else        r[c + 6] = d[c];
        end
        return r;
    endfunction

    task automatic build(input logic [19:0] en, input logic [25:0] d);
        exp_len = 0;
        for (int g = 0; g < 20; g++) begin
            if (en[g]) begin
                for (int w = 0; w < gsize(g); w++) begin
                    exp_w[exp_len] = (g == 10) ? di_model(d) : src_model(g, w);
                    exp_len++;
                end
            end
        end
        exp_w[exp_len] = '0;
        exp_len++;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic cfg_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        run_start = 1'b1;
        @(negedge clk);
        run_start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk);
        run_stop = 1'b1;
        @(negedge clk);
        run_stop = 1'b0;
        m_ready = 1'b1;
    endtask

    task automatic get_record(input string req, input bit rnd, output logic [31:0] ts);
        int n = 0;
        int idle = 0;
        bit bad = 0;
        logic [31:0] ba = '0;
        logic [31:0] be = '0;
        ts = '0;
        while (n < exp_len && idle < 4000) begin
            @(negedge clk);
            if (m_valid) begin
                if (rnd && ($urandom % 4 == 0)) begin
                    m_ready = 1'b0;
                end else begin
                    m_ready = 1'b1;
                    if (n == exp_len - 1) begin
                        ts = m_data;
                        if (!m_last && !bad) begin bad = 1; ba = 32'(m_last); be = 32'd1; end
                    end else if ((m_data !== exp_w[n] || m_last) && !bad) begin
                        bad = 1; ba = m_data; be = exp_w[n];
                    end
                    n++;
                end
            end else begin
                m_ready = 1'b1;
                idle++;
            end
        end
        m_ready = 1'b1;
        if (n != exp_len) begin bad = 1; ba = 32'(n); be = 32'(exp_len); end
        chk(!bad, req, ba, be);
    endtask

    task automatic no_valid(input int n, input string req);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (m_valid) seen++;
        end
        chk(seen == 0, req, 32'(seen), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] t1, t2;
        logic [19:0] en;
        logic [19:0] en_keep;
        int rate;
        int c1, c2;
        void'($urandom(32'h5EED));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(m_valid == 1'b0 && overflow == 1'b0, "R12 reset state", {m_valid, overflow}, 0);
        no_valid(20, "R12 idle while stopped");

        // R2/R3: empty mask, rate 0 acts as 1
        pulse_start();
        build(20'h0, din);
        get_record("R2 stamp-only record", 0, t1);
        get_record("R2 stamp-only record 2", 0, t2);
        chk(t2 - t1 == 32'd1, "R3 rate 0 as 1", t2 - t1, 32'd1);
        pulse_stop();

        // R1/R7/R3 directed layout
        din = 26'h2A5_5A3C & 26'h3FFFFFF;
        en = 20'h80C01;
        cfg_wr(4'd0, {12'd0, en});
        cfg_wr(4'd1, 32'd100);
        pulse_start();
        build(en, din);
        get_record("R1 R7 directed layout", 0, t1);
        get_record("R1 R7 directed layout 2", 0, t2);
        chk(t2 - t1 == 32'd100, "R3 period 100", t2 - t1, 32'd100);
        pulse_stop();

        // R1 random masks with backpressure
        for (int it = 0; it < 6; it++) begin
            en = 20'($urandom);
            din = 26'($urandom);
            rate = 300 + int'($urandom % 50);
            cfg_wr(4'd0, {12'd0, en});
            cfg_wr(4'd1, 32'(rate));
            pulse_start();
            build(en, din);
            get_record("R1 R11 random layout", 1, t1);
            get_record("R1 R11 random layout 2", 1, t2);
            if (it != 5) pulse_stop();
        end

        // R8: locked writes while running
        en_keep = en;
        cfg_wr(4'd0, 32'h000FFFFF);
        cfg_wr(4'd3, 32'd1);
        cfg_wr(4'd4, 32'h03030303);
        build(en_keep, din);
        get_record("R8 enable/source locked while running", 0, t1);
        pulse_stop();

        // R4 pause
        en = 20'h00020;
        cfg_wr(4'd0, {12'd0, en});
        cfg_wr(4'd1, 32'd10);
        pulse_start();
        build(en, din);
        get_record("R4 before pause", 0, t1);
        cfg_wr(4'd2, 32'd1);
        repeat (12) @(negedge clk);
        no_valid(60, "R4 no record while paused");
        cfg_wr(4'd2, 32'd0);
        get_record("R4 same layout after resume", 0, t1);
        pulse_stop();

        // R9 overflow
        cfg_wr(4'd0, 32'h000FFFFF);
        cfg_wr(4'd1, 32'd5);
        pulse_start();
        chk(overflow == 1'b0, "R9 clear after start", 32'(overflow), 32'd0);
        repeat (200) @(negedge clk);
        chk(overflow == 1'b1, "R9 dropped event flagged", 32'(overflow), 32'd1);
        pulse_stop();
        repeat (5) @(negedge clk);
        chk(overflow == 1'b1, "R9 flag sticky after stop", 32'(overflow), 32'd1);
        pulse_start();
        chk(overflow == 1'b0, "R9 start clears flag", 32'(overflow), 32'd0);
        pulse_stop();

        // R10 flush
        cfg_wr(4'd1, 32'd500);
        pulse_start();
        c1 = 0;
        while (!m_valid && c1 < 2000) begin @(negedge clk); c1++; end
        repeat (4) @(negedge clk);
        pulse_start();
        chk(m_valid == 1'b0, "R10 start flushes partial record", 32'(m_valid), 32'd0);
        build(20'hFFFFF, din);
        get_record("R10 clean record after flush", 0, t1);
        pulse_stop();
        no_valid(600, "R10 stop halts capture");

        // R5/R6 external edges: slot 5 (reg 5, lane 1), input 12, rising only
        din = '0;
        en = 20'h00800;
        cfg_wr(4'd0, {12'd0, en});
        cfg_wr(4'd1, 32'd2);
        cfg_wr(4'd3, 32'd1);
        cfg_wr(4'd4, 32'd0);
        cfg_wr(4'd5, 32'h00003100);
        pulse_start();
        no_valid(30, "R5 periodic ignored in external mode");
        build(en, din);
        @(negedge clk); din[12] = 1'b1; c1 = cyc;
        get_record("R6 slot5 input12 rising", 0, t1);
        repeat (15) @(negedge clk);
        din[12] = 1'b0;
        no_valid(20, "R5 falling ignored when rising only");
        cfg_wr(4'd5, 32'd0);
        @(negedge clk); din[12] = 1'b1; c2 = cyc;
        get_record("R8 slot write ignored while running", 0, t2);
        chk(t2 - t1 == 32'(c2 - c1), "R5 edge spacing", t2 - t1, 32'(c2 - c1));
        pulse_stop();

        // R5/R6 falling on slot 2 (reg 4 lane 2, input 3), both edges on slot 5
        din = '0;
        din[3] = 1'b1;
        cfg_wr(4'd4, 32'h000E0000);
        cfg_wr(4'd5, 32'h00003300);
        pulse_start();
        repeat (5) @(negedge clk);
        din[3] = 1'b0; c1 = cyc;
        get_record("R6 slot2 input3 falling", 0, t1);
        repeat (7) @(negedge clk);
        din[12] = 1'b1; c2 = cyc;
        get_record("R5 both-edge slot rising", 0, t2);
        chk(t2 - t1 == 32'(c2 - c1), "R5 falling-to-rising spacing", t2 - t1, 32'(c2 - c1));
        repeat (9) @(negedge clk);
        din[12] = 1'b0; c1 = cyc;
        get_record("R5 both-edge slot falling", 0, t1);
        chk(t1 - t2 == 32'(c1 - c2), "R5 rising-to-falling spacing", t1 - t2, 32'(c1 - c2));
        pulse_stop();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule